// File: doc/BRIEF.md
# SDRAM Single-Command Port

This block gives software a small register window through which it can send one SDRAM command at a time and then wait for that command to finish. Software first loads a target address. For a write-type command it also loads a transmit word. It then writes a command word. That last write is the trigger. The block checks the command word for a fixed key. If the key is good and no command is in flight, it latches the opcode, address and transmit word. It then holds a request toward a downstream SDRAM command issuer until the issuer acknowledges.

Completion is reported through two sticky flags, done and error, which software clears by writing ones. A read-type command that completes cleanly loads the returned word into a receive register. A programmable timeout limits how long the block waits for the acknowledge, and a timeout value of zero turns that limit off.

The register bus is a plain word-indexed write strobe with a combinational read port. The SDRAM pins, the data path and any arbitration sit elsewhere.

Top module: `sdcmd_port`

## Requirements
- R1: A write of the command word (index 2) whose key is good, made while idle, raises `iss_req` one cycle later. While the request is pending, `iss_addr` carries the address register (index 0), `iss_wdata` carries the transmit register (index 1), `iss_op` carries command bits [3:0], and `iss_write` equals opcode bit 3 (1 = write-type). These outputs stay stable until the request ends.
- R2: The key is command bits [31:16] and must equal 16'hA55A. A command write with any other key raises no request and sets the error flag.
- R3: An acknowledge with `iss_fail` low sets the done flag (status bit 0). An acknowledge with `iss_fail` high sets the error flag (status bit 1).
- R4: Writing the status register (index 3) clears each flag whose data bit is 1 and leaves any flag whose data bit is 0 unchanged. A flag being set in the same cycle as a clear stays set.
- R5: When a read-type command (opcode bit 3 = 0) is acknowledged without failure, the receive register (index 5) takes `iss_rdata`. A write-type command, a failed command or a rejected command leaves the receive register unchanged.
- R6: With the timeout field (control register index 4, bits [TO_W-1:0]) set to N > 0, a request not acknowledged within N cycles is dropped after exactly N cycles high. The error flag is set, the done flag is not, and an acknowledge arriving afterwards has no effect.
- R7: With the timeout field 0, a pending request stays high indefinitely until acknowledged.
- R8: A command write made while a request is pending sets the error flag and is otherwise ignored. The pending command keeps its address and opcode and still completes normally.
- R9: The request drops in the cycle after an acknowledge, so exactly one downstream command is issued per accepted command write.
- R10: After reset, all registers read 0 and the request is low. The address, transmit and control registers read back what was written, and control bits above TO_W read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index (0 addr, 1 tx, 2 cmd, 3 status, 4 ctrl, 5 rx) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| iss_req | output | 1 | Command request to the issuer, held until acknowledged or timed out |
| iss_op | output | OPW | Latched opcode |
| iss_write | output | 1 | Latched command is write-type |
| iss_addr | output | AW | Latched target address |
| iss_wdata | output | DW | Latched transmit word |
| iss_ack | input | 1 | Issuer completion pulse |
| iss_fail | input | 1 | Issuer reports failure with the acknowledge |
| iss_rdata | input | DW | Issuer read data, valid with the acknowledge |

## Verification
The bench builds the port with 32-bit address and data and a 4-bit timeout field. The narrow field makes the control register's truncation above bit 3 visible on readback. It also keeps a ten-cycle timeout window cheap to count edge by edge. The default opcode width keeps both the read-type and write-type halves of the opcode space within reach. The issuer model's latency, failure flag and a muted mode allow acknowledges to be delayed, withheld or injected late. This exercises the timeout, the in-flight rejection and the late-acknowledge cases.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam logic [15:0] CMD_KEY = 16'hA55A;
  localparam int RW = 32;

  typedef enum logic [2:0] {
    RI_ADDR = 3'd0,
    RI_TXD  = 3'd1,
    RI_CMD  = 3'd2,
    RI_STAT = 3'd3,
    RI_CTRL = 3'd4,
    RI_RXD  = 3'd5
  } reg_idx_e;

  localparam int FL_DONE = 0;
  localparam int FL_ERR  = 1;
  localparam int NFLAG   = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cmd_st_e;
endpackage

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || run) cnt_q <= cnt_d;
  end

  assign expired = run && (limit != '0) && (cnt_q == limit - TO_W'(1));
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  output logic             cmd_wr,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    txd_q,
  output logic [TO_W-1:0]  to_lim,
  input  logic [NFLAG-1:0] flag_set,
  input  logic             rx_load,
  input  logic [DW-1:0]    rx_in,
  output logic [NFLAG-1:0] flags,
  output logic [DW-1:0]    rx_q
);
  logic wr_addr, wr_txd, wr_stat, wr_ctrl;
  logic [AW-1:0]   addr_d;
  logic [DW-1:0]   txd_d, rx_d;
  logic [TO_W-1:0] lim_d;

  always_comb begin
    wr_addr = reg_we && (reg_idx == RI_ADDR);
    wr_txd  = reg_we && (reg_idx == RI_TXD);
    cmd_wr  = reg_we && (reg_idx == RI_CMD);
    wr_stat = reg_we && (reg_idx == RI_STAT);
    wr_ctrl = reg_we && (reg_idx == RI_CTRL);
    addr_d  = reg_wdata[AW-1:0];
    txd_d   = reg_wdata[DW-1:0];
    lim_d   = reg_wdata[TO_W-1:0];
    rx_d    = rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      txd_q  <= '0;
      to_lim <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_addr) addr_q <= addr_d;
      if (wr_txd)  txd_q  <= txd_d;
      if (wr_ctrl) to_lim <= lim_d;
      if (rx_load) rx_q   <= rx_d;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic fl_d;
    always_comb begin
      fl_d = flags[g];
      if (flag_set[g])                  fl_d = 1'b1;
      else if (wr_stat && reg_wdata[g]) fl_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= fl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      RI_ADDR: reg_rdata[AW-1:0]    = addr_q;
      RI_TXD:  reg_rdata[DW-1:0]    = txd_q;
      RI_STAT: reg_rdata[NFLAG-1:0] = flags;
      RI_CTRL: reg_rdata[TO_W-1:0]  = to_lim;
      RI_RXD:  reg_rdata[DW-1:0]    = rx_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_key,
  input  logic [OPW-1:0]   cmd_op,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    txd_in,
  input  logic             iss_ack,
  input  logic             iss_fail,
  input  logic             tmo,
  output logic             start,
  output logic             busy,
  output logic [OPW-1:0]   op_q,
  output logic [AW-1:0]    ad_q,
  output logic [DW-1:0]    wd_q,
  output logic [NFLAG-1:0] flag_set,
  output logic             rx_load
);
  cmd_st_e        st_q, st_d;
  logic [OPW-1:0] op_d;
  logic [AW-1:0]  ad_d;
  logic [DW-1:0]  wd_d;
  logic           key_ok;

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    ad_d     = ad_q;
    wd_d     = wd_q;
    start    = 1'b0;
    flag_set = '0;
    rx_load  = 1'b0;
    key_ok   = (cmd_key == CMD_KEY);
    case (st_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          if (key_ok) begin
            start = 1'b1;
            st_d  = ST_BUSY;
            op_d  = cmd_op;
            ad_d  = addr_in;
            wd_d  = txd_in;
          end else begin
            flag_set[FL_ERR] = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        if (cmd_wr) flag_set[FL_ERR] = 1'b1;
        if (iss_ack) begin
          st_d = ST_IDLE;
          if (iss_fail) begin
            flag_set[FL_ERR] = 1'b1;
          end else begin
            flag_set[FL_DONE] = 1'b1;
            rx_load = !op_q[OPW-1];
          end
        end else if (tmo) begin
          st_d = ST_IDLE;
          flag_set[FL_ERR] = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= '0;
      ad_q <= '0;
      wd_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        op_q <= op_d;
        ad_q <= ad_d;
        wd_q <= wd_d;
      end
    end
  end

  assign busy = (st_q == ST_BUSY);
endmodule

// File: rtl/sdcmd_port.sv
module sdcmd_port
  import sdcmd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OPW  = 4,
  parameter int TO_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_idx,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           iss_req,
  output logic [OPW-1:0] iss_op,
  output logic           iss_write,
  output logic [AW-1:0]  iss_addr,
  output logic [DW-1:0]  iss_wdata,
  input  logic           iss_ack,
  input  logic           iss_fail,
  input  logic [DW-1:0]  iss_rdata
);
  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic             cmd_wr, start, busy, tmo, rx_load;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    txd_q, rx_val;
  logic [TO_W-1:0]  to_lim;
  logic [NFLAG-1:0] flag_set, flags;
  logic             flag_done, flag_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  sdcmd_regs #(.AW(AW), .DW(DW), .TO_W(TO_W)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
    .addr_q(addr_q), .txd_q(txd_q), .to_lim(to_lim), .flag_set(flag_set),
    .rx_load(rx_load), .rx_in(iss_rdata), .flags(flags), .rx_q(rx_val)
  );

  sdcmd_ctrl #(.AW(AW), .DW(DW), .OPW(OPW)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .cmd_wr(cmd_wr), .cmd_key(reg_wdata[31:16]),
    .cmd_op(reg_wdata[OPW-1:0]), .addr_in(addr_q), .txd_in(txd_q),
    .iss_ack(iss_ack), .iss_fail(iss_fail), .tmo(tmo), .start(start),
    .busy(busy), .op_q(iss_op), .ad_q(iss_addr), .wd_q(iss_wdata),
    .flag_set(flag_set), .rx_load(rx_load)
  );

  sdcmd_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .clr(start), .run(busy),
    .limit(to_lim), .expired(tmo)
  );

  assign iss_req   = busy;
  assign iss_write = iss_op[OPW-1];
  assign flag_done = flags[FL_DONE];
  assign flag_err  = flags[FL_ERR];
endmodule

// File: rtl/sdcmd_port_chk.sv
module sdcmd_port_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OPW  = 4,
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_idx,
  input logic [15:0]     wd_key,
  input logic            wd_b0,
  input logic            iss_req,
  input logic            iss_ack,
  input logic            iss_fail,
  input logic [OPW-1:0]  iss_op,
  input logic [AW-1:0]   iss_addr,
  input logic            flag_done,
  input logic            flag_err,
  input logic [DW-1:0]   rx_val,
  input logic [TO_W-1:0] to_lim
);
  logic cmd_w, stat_w;
  assign cmd_w  = reg_we && (reg_idx == 3'd2);
  assign stat_w = reg_we && (reg_idx == 3'd3);

  AST_PARAMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req && !iss_ack |=> $stable(iss_addr) && $stable(iss_op)); // R1
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_req && cmd_w && (wd_key != 16'hA55A) |=> !iss_req && flag_err); // R2
  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req && iss_ack && !iss_fail |=> flag_done); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_done && !(stat_w && wd_b0) |=> flag_done); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_req && iss_ack) |=> $stable(rx_val)); // R5
  AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req && !iss_ack && (to_lim == '0) |=> iss_req); // R7
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req && cmd_w |=> flag_err); // R8
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_req && iss_ack |=> !iss_req); // R9
endmodule

bind sdcmd_port sdcmd_port_chk #(.AW(AW), .DW(DW), .OPW(OPW), .TO_W(TO_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .reg_we(reg_we), .reg_idx(reg_idx),
  .wd_key(reg_wdata[31:16]), .wd_b0(reg_wdata[0]), .iss_req(iss_req),
  .iss_ack(iss_ack), .iss_fail(iss_fail), .iss_op(iss_op), .iss_addr(iss_addr),
  .flag_done(flag_done), .flag_err(flag_err), .rx_val(rx_val), .to_lim(to_lim)
);

// File: tb/sdcmd_port_bench.sv
module sdcmd_port_bench;
  localparam int AW = 32, DW = 32, OPW = 4, TO_W = 4;
  localparam int NV = 7;
  localparam int VW = 172;
  // {cmd, addr, tx, rdat, exp_rx, lat[7:0], fail, exp_stat[1:0], exp_issue}
  localparam logic [VW-1:0] TBL [0:NV-1] = '{
    {32'hA55A_0001, 32'h0000_0100, 32'h1111_1111, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd2, 1'b0, 2'b01, 1'b1},
    {32'hA55A_0009, 32'h0000_0200, 32'h1234_5678, 32'hFFFF_0000, 32'hDEAD_BEEF, 8'd0, 1'b0, 2'b01, 1'b1},
    {32'hA55A_0002, 32'h0000_0300, 32'h0000_0000, 32'h0BAD_F00D, 32'hDEAD_BEEF, 8'd3, 1'b1, 2'b10, 1'b1},
    {32'h5AA5_0001, 32'h0000_0400, 32'h0000_0000, 32'h7777_7777, 32'hDEAD_BEEF, 8'd1, 1'b0, 2'b10, 1'b0},
    {32'hA55A_0005, 32'h0000_03FC, 32'h0000_0000, 32'hCAFE_0001, 32'hCAFE_0001, 8'd7, 1'b0, 2'b01, 1'b1},
    {32'hA55A_000F, 32'h0000_0500, 32'hABCD_EF01, 32'h5555_5555, 32'hCAFE_0001, 8'd1, 1'b1, 2'b10, 1'b1},
    {32'hA55A_FFF3, 32'h0000_0600, 32'h0000_0000, 32'h0000_0042, 32'h0000_0042, 8'd1, 1'b0, 2'b01, 1'b1}
  };

  logic clk, rst_n, reg_we;
  logic [2:0] reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic iss_req, iss_write, iss_ack, iss_fail;
  logic [OPW-1:0] iss_op;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_wdata, iss_rdata;

  logic mdl_ack, inj_ack, cfg_fail, cfg_mute, m_busy, fin;
  logic [31:0] cfg_rdata, cap_addr, cap_wdata;
  logic [3:0] cap_op;
  logic cap_wr;
  int cfg_lat, m_cnt, cap_cnt;
  int n_chk, n_bad;

  assign iss_ack   = mdl_ack | inj_ack;
  assign iss_fail  = cfg_fail;
  assign iss_rdata = cfg_rdata;

  sdcmd_port #(.AW(AW), .DW(DW), .OPW(OPW), .TO_W(TO_W)) u_sdcmd_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iss_req(iss_req),
    .iss_op(iss_op), .iss_write(iss_write), .iss_addr(iss_addr),
    .iss_wdata(iss_wdata), .iss_ack(iss_ack), .iss_fail(iss_fail),
    .iss_rdata(iss_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // issuer model
  initial begin
    mdl_ack = 0; m_busy = 0; m_cnt = 0; cap_cnt = 0;
    cap_addr = 0; cap_wdata = 0; cap_op = 0; cap_wr = 0;
  end
  always @(negedge clk) begin
    if (mdl_ack) mdl_ack = 1'b0;
    else if (!m_busy && iss_req) begin
      cap_cnt++; cap_addr = iss_addr; cap_wdata = iss_wdata;
      cap_op = iss_op; cap_wr = iss_write;
      if (cfg_lat == 0 && !cfg_mute) mdl_ack = 1'b1;
      else begin m_busy = 1'b1; m_cnt = cfg_lat; end
    end else if (m_busy && !iss_req) m_busy = 1'b0;
    else if (m_busy) begin
      if (m_cnt > 0) m_cnt--;
      if (m_cnt == 0 && !cfg_mute) begin mdl_ack = 1'b1; m_busy = 1'b0; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk); reg_idx = idx; #1; v = reg_rdata;
  endtask

  task automatic pulse_inj;
    @(negedge clk); inj_ack = 1'b1;
    @(negedge clk); inj_ack = 1'b0;
  endtask

  initial begin
    fin = 0;
    #(8 * 150000);
    if (!fin) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [VW-1:0] t;
    int c0, hi;
    n_chk = 0; n_bad = 0;
    rst_n = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    inj_ack = 0; cfg_fail = 0; cfg_mute = 0; cfg_lat = 0; cfg_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 req after reset", {31'd0, iss_req}, 0);
    rd(3'd3, v); chk("R10 status reset", v, 0);
    rd(3'd5, v); chk("R10 rx reset", v, 0);
    rd(3'd0, v); chk("R10 addr reset", v, 0);
    rd(3'd4, v); chk("R10 ctrl reset", v, 0);
    // R10 readback
    wr(3'd0, 32'h89AB_CDEF); rd(3'd0, v); chk("R10 addr readback", v, 32'h89AB_CDEF);
    wr(3'd1, 32'h0F0F_1234); rd(3'd1, v); chk("R10 tx readback", v, 32'h0F0F_1234);
    wr(3'd4, 32'hFFFF_FFFA); rd(3'd4, v); chk("R10 ctrl truncation", v, 32'h0000_000A);
    wr(3'd4, 32'h0);

    // table walk: R1 R2 R3 R5 R9
    for (int i = 0; i < NV; i++) begin
      t = TBL[i];
      cfg_lat = int'(t[11:4]); cfg_fail = t[3]; cfg_rdata = t[75:44];
      wr(3'd0, t[139:108]);
      wr(3'd1, t[107:76]);
      c0 = cap_cnt;
      wr(3'd2, t[171:140]);
      repeat (cfg_lat + 6) @(negedge clk);
      rd(3'd3, v); chk($sformatf("R3 status vec %0d", i), v, {30'd0, t[2:1]});
      rd(3'd5, v); chk($sformatf("R5 rx vec %0d", i), v, t[43:12]);
      chk($sformatf("R9 issue count vec %0d", i), cap_cnt - c0, {31'd0, t[0]});
      if (t[0]) begin
        chk($sformatf("R1 addr vec %0d", i), cap_addr, t[139:108]);
        chk($sformatf("R1 op vec %0d", i), {28'd0, cap_op}, {28'd0, t[143:140]});
        chk($sformatf("R1 write flag vec %0d", i), {31'd0, cap_wr}, {31'd0, t[143]});
        if (t[143]) chk($sformatf("R1 wdata vec %0d", i), cap_wdata, t[107:76]);
      end else begin
        chk($sformatf("R2 bad key no req vec %0d", i), {31'd0, iss_req}, 0);
      end
      wr(3'd3, 32'h3);
    end
    rd(3'd3, v); chk("R4 all cleared", v, 0);

    // R4 partial clear
    cfg_lat = 1; cfg_fail = 0; cfg_rdata = 32'h2468_ACE0;
    wr(3'd2, 32'h1234_0001);
    wr(3'd2, 32'hA55A_0001);
    repeat (8) @(negedge clk);
    rd(3'd3, v); chk("R4 both flags set", v, 32'h3);
    wr(3'd3, 32'h0); rd(3'd3, v); chk("R4 write zero keeps", v, 32'h3);
    wr(3'd3, 32'h1); rd(3'd3, v); chk("R4 clear done only", v, 32'h2);
    wr(3'd3, 32'h2); rd(3'd3, v); chk("R4 clear err", v, 32'h0);

    // R7 / R8 in-flight rejection with no timeout
    cfg_mute = 1; cfg_rdata = 32'h1357_9BDF;
    wr(3'd0, 32'h0000_0A00);
    c0 = cap_cnt;
    wr(3'd2, 32'hA55A_0004);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h0000_0B00);
    wr(3'd2, 32'hA55A_0006);
    rd(3'd3, v); chk("R8 busy write sets err", v, 32'h2);
    chk("R8 addr kept", iss_addr, 32'h0000_0A00);
    chk("R8 op kept", {28'd0, iss_op}, 32'h4);
    repeat (300) @(negedge clk);
    chk("R7 req still high", {31'd0, iss_req}, 1);
    pulse_inj;
    repeat (3) @(negedge clk);
    chk("R9 req dropped after ack", {31'd0, iss_req}, 0);
    rd(3'd3, v); chk("R8 pending cmd completes", v, 32'h3);
    rd(3'd5, v); chk("R5 rx from in-flight read", v, 32'h1357_9BDF);
    chk("R8 single issue", cap_cnt - c0, 1);
    wr(3'd3, 32'h3);

    // R6 timeout
    wr(3'd4, 32'd10);
    cfg_rdata = 32'hEEEE_EEEE;
    wr(3'd2, 32'hA55A_0001);
    hi = iss_req ? 1 : 0;
    repeat (29) begin @(negedge clk); if (iss_req) hi++; end
    chk("R6 cycles high", hi, 10);
    rd(3'd3, v); chk("R6 timeout sets err only", v, 32'h2);
    c0 = cap_cnt;
    pulse_inj;
    repeat (3) @(negedge clk);
    rd(3'd3, v); chk("R6 late ack ignored status", v, 32'h2);
    rd(3'd5, v); chk("R6 late ack ignored rx", v, 32'h1357_9BDF);
    chk("R6 no new issue", cap_cnt - c0, 0);
    cfg_mute = 0;

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule